// File: doc/BRIEF.md
# Microsecond Free-Running Timer with Coherent Byte Reads

This block keeps a 12-bit count that advances once per microsecond and wraps around on its own, with no software action needed. A prescaler divides the system clock down to a one-cycle tick at 1 MHz. At the default settings the system clock is 12 MHz and the divide ratio is 12. Software measures the length of an event by reading the count at its start and again at its end, then taking the difference.

Reads go through an 8-bit port that has two addresses. The low address returns the lower eight count bits. A read of the low address also copies the upper four bits into a holding register. The high address returns that held copy and not the live count. A low read followed by a high read therefore gives one consistent 12-bit value, even when the count carries into its upper bits between the two reads.

The block also gives two periodic interrupt strobes, each one clock wide. The first fires once every 128 counts (128 µs) and the second once every 1024 counts (1.024 ms). Each is taken from a carry inside the counter.

Top module: `usec_free_timer`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, the count, the prescaler and the holding register are zero. `irq_fast` and `irq_slow` are low, and `rd_data` reads zero at both addresses. `rst` is synchronous and active high.
- R2: The count advances by exactly one on the CLK_DIV-th rising edge after reset release, and on every CLK_DIV-th edge after that. After n edges it reads floor(n / CLK_DIV) modulo 4096.
- R3: The count wraps from 4095 to 0 and keeps running with no other input.
- R4: When `rd_sel` is 0 (low address), `rd_data` shows count bits 7:0 in the same cycle, whatever the level of `rd_en`.
- R5: A clock edge that sees `rd_en`=1 with `rd_sel`=0 loads count bits 11:8 into the holding register. If the count advances at that same edge, the value loaded is the one from before the advance, so it matches the low byte returned in that cycle.
- R6: When `rd_sel` is 1 (high address), `rd_data` is {4'b0000, holding register}, so bits 7:4 read 0. Reads of the high address and idle cycles leave the holding register unchanged, even while the live count moves on.
- R7: `irq_fast` is high for exactly one cycle, in the cycle after the edge where count bits 6:0 roll over from 127 to 0. This happens once every 128 counts.
- R8: `irq_slow` is high for exactly one cycle, in the cycle after the edge where count bits 9:0 roll over from 1023 to 0. This happens once every 1024 counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe; with `rd_sel`=0 it captures the upper bits |
| rd_sel | input | 1 | Read address: 0 = low byte, 1 = held upper nibble |
| rd_data | output | 8 | Read data, combinational from `rd_sel` |
| irq_fast | output | 1 | One-cycle strobe every 128 counts |
| irq_slow | output | 1 | One-cycle strobe every 1024 counts |

## Verification
The main instance is built with CLK_DIV=3 and the default widths. This lets the bench step through more than two full wraps of the 12-bit count, and every rollover of both interrupt taps, within about 25,000 cycles. At every cycle of that run, the bench compares the low byte, the held nibble and both strobes against values it works out from the cycle count. A second instance with CLK_DIV=2 tests the shortest legal divide ratio. The bench also places low reads on the exact edges where the low byte carries from 0xFF, to test the capture of the value from before the advance.

// File: rtl/ftmr_pkg.sv
package ftmr_pkg;
   typedef enum logic {
      SEL_LOW  = 1'b0,
      SEL_HIGH = 1'b1
   } ftmr_sel_e;
endpackage

// File: rtl/ftmr_prescale.sv
module ftmr_prescale #(
   parameter int CLK_DIV = 12
) (
   input  logic clk,
   input  logic rst,
   output logic tick
);
   localparam int PW = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
   localparam logic [PW-1:0] LAST = PW'(CLK_DIV - 1);

   logic [PW-1:0] phase_q;

   assign tick = (phase_q == LAST);

   always_ff @(posedge clk) begin
      if (rst)        phase_q <= '0;
      else if (tick)  phase_q <= '0;
      else            phase_q <= phase_q + 1'b1;
   end

   // R2: a tick never lasts two cycles when the divide is at least two
   p_tick_single_r2: assert property (@(posedge clk) disable iff (rst)
      tick |=> !tick);
endmodule

// File: rtl/ftmr_count.sv
module ftmr_count #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   output logic [CNT_W-1:0] count
);
   logic [CNT_W-1:0] count_q;

   assign count = count_q;

   always_ff @(posedge clk) begin
      if (rst)       count_q <= '0;
      else if (tick) count_q <= count_q + 1'b1;
   end

   // R2, R3: one step per tick, modulo 2^CNT_W
   p_step_r2: assert property (@(posedge clk) disable iff (rst)
      tick |=> count_q == CNT_W'($past(count_q) + 1'b1));
   p_hold_still_r3: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(count_q));
endmodule

// File: rtl/ftmr_hold.sv
module ftmr_hold #(
   parameter int HI_W = 4
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            capture,
   input  logic [HI_W-1:0] upper_in,
   output logic [HI_W-1:0] held
);
   logic [HI_W-1:0] held_q;

   assign held = held_q;

   always_ff @(posedge clk) begin
      if (rst)          held_q <= '0;
      else if (capture) held_q <= upper_in;
   end

   // R5: capture takes the upper bits seen in the read cycle
   p_capture_r5: assert property (@(posedge clk) disable iff (rst)
      capture |=> held_q == $past(upper_in));
   // R6: nothing but a low read changes the held nibble
   p_keep_r6: assert property (@(posedge clk) disable iff (rst)
      !capture |=> $stable(held_q));
endmodule

// File: rtl/ftmr_tap.sv
module ftmr_tap #(
   parameter int CNT_W = 12,
   parameter int TAP   = 6
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   input  logic [CNT_W-1:0] count,
   output logic             strobe
);
   logic strobe_q;

   assign strobe = strobe_q;

   always_ff @(posedge clk) begin
      if (rst) strobe_q <= 1'b0;
      else     strobe_q <= tick && (&count[TAP:0]);
   end

   // R7, R8: the strobe is one cycle wide
   p_one_wide_r7: assert property (@(posedge clk) disable iff (rst)
      strobe_q |=> !strobe_q);
   // R7, R8: the strobe is seen only just after the low bits rolled to zero
   p_rollover_r8: assert property (@(posedge clk) disable iff (rst)
      strobe_q |-> (count[TAP:0] == '0));
endmodule

// File: rtl/usec_free_timer.sv
module usec_free_timer
   import ftmr_pkg::*;
#(
   parameter int CLK_DIV  = 12,
   parameter int CNT_W    = 12,
   parameter int LO_W     = 8,
   parameter int DATA_W   = 8,
   parameter int TAP_FAST = 6,
   parameter int TAP_SLOW = 9
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rd_en,
   input  logic              rd_sel,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq_fast,
   output logic              irq_slow
);
   localparam int HI_W   = CNT_W - LO_W;
   localparam int N_TAPS = 2;

   initial begin
      assert (CLK_DIV >= 2) else $error("CLK_DIV must be at least 2");
      assert (LO_W >= 1 && LO_W < CNT_W) else $error("LO_W out of range");
      assert (LO_W <= DATA_W && HI_W <= DATA_W) else $error("DATA_W too narrow");
      assert (TAP_FAST < CNT_W && TAP_SLOW < CNT_W) else $error("tap beyond counter");
   end

   logic             tick;
   logic [CNT_W-1:0] count;
   logic [HI_W-1:0]  held;
   logic [N_TAPS-1:0] strobes;
   logic             capture;

   assign capture = rd_en && (ftmr_sel_e'(rd_sel) == SEL_LOW);

   ftmr_prescale #(.CLK_DIV(CLK_DIV)) u_pre (
      .clk(clk), .rst(rst), .tick(tick));

   ftmr_count #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .tick(tick), .count(count));

   ftmr_hold #(.HI_W(HI_W)) u_hold (
      .clk(clk), .rst(rst), .capture(capture),
      .upper_in(count[CNT_W-1:LO_W]), .held(held));

   for (genvar i = 0; i < N_TAPS; i++) begin : g_tap
      localparam int TP = (i == 0) ? TAP_FAST : TAP_SLOW;
      ftmr_tap #(.CNT_W(CNT_W), .TAP(TP)) u_tap (
         .clk(clk), .rst(rst), .tick(tick), .count(count),
         .strobe(strobes[i]));
   end

   assign irq_fast = strobes[0];
   assign irq_slow = strobes[1];

   always_comb begin
      if (ftmr_sel_e'(rd_sel) == SEL_HIGH) rd_data = DATA_W'(held);
      else                                 rd_data = DATA_W'(count[LO_W-1:0]);
   end

   // R6: upper bits of a high read are zero
   p_high_pad_r6: assert property (@(posedge clk) disable iff (rst)
      rd_sel |-> (rd_data >> HI_W) == '0);
   // R1: nothing fires in the first cycle after reset
   p_quiet_after_reset_r1: assert property (@(posedge clk)
      rst |=> !irq_fast && !irq_slow);
endmodule

// File: tb/usec_free_timer_test.sv
module usec_free_timer_test;
   localparam int CLK_PERIOD = 10;
   localparam int DIV   = 3;
   localparam int F_DIV = 2;
   localparam int RUN   = 4096 * DIV * 2 + 500;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic rd_en = 1'b0;
   logic rd_sel = 1'b1;
   logic [7:0] rd_data, f_data;
   logic irq_fast, irq_slow, f_irq_fast, f_irq_slow;

   int cyc = 0;
   int n_checks = 0;
   int n_fails = 0;
   int exp_hold = 0;
   bit hold_coinc = 1'b0;
   bit active = 1'b0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   usec_free_timer #(.CLK_DIV(DIV)) uut (
      .clk(clk), .rst(rst), .rd_en(rd_en), .rd_sel(rd_sel),
      .rd_data(rd_data), .irq_fast(irq_fast), .irq_slow(irq_slow));

   usec_free_timer #(.CLK_DIV(F_DIV)) uut_fast (
      .clk(clk), .rst(rst), .rd_en(1'b0), .rd_sel(1'b0),
      .rd_data(f_data), .irq_fast(f_irq_fast), .irq_slow(f_irq_slow));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (rst) cyc <= 0;
      else     cyc <= cyc + 1;
   end

   // per-cycle comparison against arithmetic expectations
   always @(negedge clk) begin
      if (active && !rst) begin
         automatic int cnt = (cyc / DIV) % 4096;
         automatic bit ef = (cyc > 0) && (cyc % (128 * DIV) == 0);
         automatic bit es = (cyc > 0) && (cyc % (1024 * DIV) == 0);
         if (rd_sel == 1'b0) begin
            chk(rd_data == 8'(cnt % 256), (cyc / DIV >= 4096) ? "R3" :
                (rd_en ? "R4" : "R2"), int'(rd_data), cnt % 256);
            if (rd_en) begin
               exp_hold = cnt / 256;
               hold_coinc = (cyc % DIV == DIV - 1) && (cnt % 256 == 255);
            end
         end else begin
            chk(rd_data == 8'(exp_hold), hold_coinc ? "R5" : "R6",
                int'(rd_data), exp_hold);
         end
         chk(irq_fast == ef, "R7", int'(irq_fast), int'(ef));
         chk(irq_slow == es, "R8", int'(irq_slow), int'(es));
         chk(f_data == 8'((cyc / F_DIV) % 256), "R2", int'(f_data), (cyc / F_DIV) % 256);
         chk(f_irq_fast == ((cyc > 0) && (cyc % (128 * F_DIV) == 0)), "R7",
             int'(f_irq_fast), int'((cyc > 0) && (cyc % (128 * F_DIV) == 0)));
      end
   end

   task automatic reset_checks();
      @(negedge clk);
      rd_sel = 1'b1;
      #1;
      chk(rd_data == 8'd0, "R1", int'(rd_data), 0);
      chk(!irq_fast && !irq_slow, "R1", int'(irq_fast) + int'(irq_slow), 0);
      rd_sel = 1'b0;
      #1;
      chk(rd_data == 8'd0, "R1", int'(rd_data), 0);
   endtask

   task automatic run_cycles(input int last);
      int force_hi = 0;
      while (cyc < last) begin
         @(posedge clk); #1;
         if ((cyc % DIV == DIV - 1) && (((cyc / DIV) % 256) == 255)) begin
            rd_en = 1'b1; rd_sel = 1'b0; force_hi = 3;   // R5 coincident read
         end else if (force_hi > 0) begin
            rd_en = force_hi[0]; rd_sel = 1'b1; force_hi--;
         end else begin
            case (cyc % 11)
               0:       begin rd_en = 1'b1; rd_sel = 1'b0; end
               1, 2, 5: begin rd_en = cyc[0]; rd_sel = 1'b1; end
               default: begin rd_en = 1'b0; rd_sel = 1'b0; end
            endcase
         end
      end
      @(posedge clk); #1;
      rd_en = 1'b0; rd_sel = 1'b0;
   endtask

   task automatic do_reset(input int cycles);
      @(posedge clk); #1;
      active = 1'b0;
      rst = 1'b1; rd_en = 1'b0;
      repeat (cycles) @(posedge clk);
      #1;
      exp_hold = 0; hold_coinc = 1'b0;
      reset_checks();
      @(posedge clk); #1;
      rst = 1'b0;
      reset_checks();          // R1: cycle after release
      active = 1'b1;
   endtask

   initial begin
      do_reset(4);
      run_cycles(RUN);
      do_reset(2);             // R1: reset in mid-run clears everything
      run_cycles(1200 * DIV);
      active = 1'b0;
      done = 1'b1;
   end

   initial begin
      int w = 0;
      while (!done && w < 200000) begin
         @(posedge clk);
         w++;
      end
      if (!done) begin
         n_checks++; n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
      end
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
   end
endmodule